// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a system clock into the bit-level timing of a CAN node. A programmable divider produces a time-quantum tick. A small sequencer steps once per quantum through the parts of each bit: a one-quantum sync slot, then a first segment that covers both propagation and phase 1, then phase 2. At the boundary between the first segment and phase 2 it latches the receive line and emits a one-cycle sample strobe for the bit stream processor. At the start of every sync slot it emits a bit-start strobe and updates the transmit line.

All four timing fields come from a single 16-bit configuration word. Each field holds its real length minus one. Falling edges on the receive line realign the bit timing. When the bit stream processor enables hard sync, such an edge restarts the bit. Otherwise it stretches phase 1 or trims phase 2, and the size of that correction is capped by a programmed jump width.

Top module: `can_bit_timer`

## Requirements
- R1: `cfg_word` is decoded as prescaler `[5:0]`, jump width `[7:6]`, first segment `[11:8]` and phase 2 `[14:12]`. Each field is its functional length minus one, and bit 15 has no effect.
- R2: One quantum lasts prescaler+1 clocks. With no edges on the receive line, consecutive `sample_stb` pulses are (first+phase2+3)·(prescaler+1) clocks apart, and the gap from a sample to the next `bit_start_stb` is (phase2+1)·(prescaler+1).
- R3: `sample_stb` is a one-cycle pulse (first+2)·(prescaler+1) clocks after `bit_start_stb`. It never coincides with `bit_start_stb`. In that cycle, and until the next sample, `rx_bit` holds the value `rx_in` had at the sample edge.
- R4: `tx_out` only changes in the cycle where `bit_start_stb` is high, and it takes the `tx_bit_in` value present at that edge.
- R5: During reset `tx_out` and `rx_bit` are 1 (recessive), and both strobes are 0.
- R6: With `hsync_en`=1, a falling edge is detected at the first clock edge E where `rx_in` is 0 after being 1 on the edge before. It raises `bit_start_stb` in the cycle after E, restarts the prescaler, and places the next sample (first+2)·(prescaler+1) clocks after E.
- R7: With `hsync_en`=0, an edge detected in quantum k (counted from 0) of the first segment delays that bit's sample by min(k+1, jump+1) quanta.
- R8: With `hsync_en`=0, an edge detected in quantum k of phase 2 shortens phase 2 by min(phase2−k, jump+1) quanta.
- R9: At most one resynchronization happens between two samples. Further edges in that window leave the timing unchanged.
- R10: Resynchronization only occurs if the most recent sample was recessive (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Packed bit-timing configuration, held static outside reset |
| rx_in | input | 1 | Receive line, 0 = dominant |
| hsync_en | input | 1 | Selects hard sync instead of resynchronization on falling edges |
| tx_bit_in | input | 1 | Next bit to transmit |
| tx_out | output | 1 | Transmit line, registered |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| rx_bit | output | 1 | Receive bit latched at the last sample point |
| bit_start_stb | output | 1 | One-cycle pulse at the start of each sync slot |

## Verification
The bench goes after the quantum counts around each correction.

- **Phase-1 stretch (R7):** an edge early in the first segment must delay the sample by exactly the phase error. An off-by-one in the error term would land the sample a full quantum too late or too early.
- **Phase-2 trim (R8):** a trim that ignores the jump cap shortens phase 2 too much.
- **Once-per-window (R9):** a second edge inside one sample window must not move the sample again. A design that re-arms on every edge would stretch twice.
- **Dominant-sample lockout (R10):** a bit whose last sample was dominant must not resynchronize. A design missing the recessive-sample condition would shift that sample.

Hard sync (R6) is checked against the exact strobe cycles. The widest and narrowest field encodings, including bit 15 set, are checked against the strobe spacing that R2 and R3 predict.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int CFG_WORD_W = 16;
  localparam int PRESC_W    = 6;
  localparam int JUMP_W     = 2;
  localparam int SEG1_W     = 4;
  localparam int SEG2_W     = 3;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             restart,
  output logic             tq_tick
);

  logic [DIV_W-1:0] div_cnt;

  assign tq_tick = (div_cnt == div_m1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_cnt <= '0;
    end else if (tq_tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (div_m1 != '0 && tq_tick) |=> !tq_tick); // R2

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_fall
);

  logic rx_last;

  always_ff @(posedge clk) begin
    if (rst) rx_last <= 1'b1;
    else     rx_last <= rx_in;
  end

  assign rx_fall = rx_last & ~rx_in;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_fall |=> !rx_fall); // R6

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int JUMP_W = 2,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [JUMP_W-1:0] jump_m1,
  input  logic [SEG1_W-1:0] seg1_m1,
  input  logic [SEG2_W-1:0] seg2_m1,
  input  logic              tq_tick,
  input  logic              rx_in,
  input  logic              rx_fall,
  input  logic              hsync_en,
  input  logic              tx_bit_in,
  output logic              hard_sync,
  output logic              tx_out,
  output logic              sample_stb,
  output logic              rx_bit,
  output logic              bit_start_stb
);

  seg_e             seg;
  logic [CNT_W-1:0] qcnt;
  logic [CNT_W-1:0] stretch;
  logic [CNT_W-1:0] trim;
  logic             armed;

  logic [CNT_W-1:0] qnext;
  logic [CNT_W-1:0] ph1_lim;
  logic [CNT_W-1:0] ph2_lim;
  logic [CNT_W-1:0] ph2_nom_m1;
  logic [CNT_W-1:0] jump_len;
  logic [CNT_W-1:0] phase_err;
  logic [CNT_W-1:0] jump_amt;
  logic             resync_go;

  always_comb begin
    qnext      = qcnt + CNT_W'(1);
    ph1_lim    = CNT_W'(seg1_m1) + CNT_W'(1) + stretch;
    ph2_nom_m1 = CNT_W'(seg2_m1);
    ph2_lim    = ph2_nom_m1 + CNT_W'(1) - trim;
    jump_len   = CNT_W'(jump_m1) + CNT_W'(1);
    case (seg)
      SEG_PH1: phase_err = qnext;
      SEG_PH2: phase_err = ph2_nom_m1 - qcnt;
      default: phase_err = '0;
    endcase
    jump_amt  = (phase_err < jump_len) ? phase_err : jump_len;
    hard_sync = rx_fall & hsync_en;
    resync_go = rx_fall & ~hsync_en & armed & (seg != SEG_SYNC) & (phase_err != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg           <= SEG_SYNC;
      qcnt          <= '0;
      stretch       <= '0;
      trim          <= '0;
      armed         <= 1'b0;
      tx_out        <= 1'b1;
      rx_bit        <= 1'b1;
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
    end else begin
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
      if (hard_sync) begin
        seg           <= SEG_SYNC;
        qcnt          <= '0;
        stretch       <= '0;
        trim          <= '0;
        armed         <= 1'b0;
        bit_start_stb <= 1'b1;
        tx_out        <= tx_bit_in;
      end else begin
        if (resync_go) begin
          if (seg == SEG_PH1) stretch <= jump_amt;
          else                trim    <= jump_amt;
          armed <= 1'b0;
        end
        if (tq_tick) begin
          case (seg)
            SEG_SYNC: begin
              seg  <= SEG_PH1;
              qcnt <= '0;
            end
            SEG_PH1: begin
              if (qnext >= ph1_lim) begin
                seg        <= SEG_PH2;
                qcnt       <= '0;
                sample_stb <= 1'b1;
                rx_bit     <= rx_in;
                armed      <= rx_in;
              end else begin
                qcnt <= qnext;
              end
            end
            SEG_PH2: begin
              if (qnext >= ph2_lim) begin
                seg           <= SEG_SYNC;
                qcnt          <= '0;
                stretch       <= '0;
                trim          <= '0;
                bit_start_stb <= 1'b1;
                tx_out        <= tx_bit_in;
              end else begin
                qcnt <= qnext;
              end
            end
            default: begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end
          endcase
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !bit_start_stb); // R3
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_start_stb |-> $stable(tx_out)); // R4
  AST_HS_START: assert property (@(posedge clk) disable iff (rst)
    hard_sync |=> bit_start_stb); // R6
  AST_STRETCH_CAP: assert property (@(posedge clk) disable iff (rst)
    stretch <= jump_len); // R7
  AST_TRIM_CAP: assert property (@(posedge clk) disable iff (rst)
    trim <= jump_len); // R8

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int CFG_W   = CFG_WORD_W,
  parameter int PRESC_W = can_bt_pkg::PRESC_W,
  parameter int JUMP_W  = can_bt_pkg::JUMP_W,
  parameter int SEG1_W  = can_bt_pkg::SEG1_W,
  parameter int SEG2_W  = can_bt_pkg::SEG2_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             rx_in,
  input  logic             hsync_en,
  input  logic             tx_bit_in,
  output logic             tx_out,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             bit_start_stb
);

  localparam int JUMP_LSB = PRESC_W;
  localparam int SEG1_LSB = JUMP_LSB + JUMP_W;
  localparam int SEG2_LSB = SEG1_LSB + SEG1_W;
  localparam int USED_W   = SEG2_LSB + SEG2_W;
  localparam int WIDE_W   = (SEG1_W > JUMP_W) ? SEG1_W : JUMP_W;
  localparam int CNT_W    = WIDE_W + 2;

  logic [PRESC_W-1:0] presc_m1;
  logic [JUMP_W-1:0]  jump_m1;
  logic [SEG1_W-1:0]  seg1_m1;
  logic [SEG2_W-1:0]  seg2_m1;
  logic               tq_tick;
  logic               rx_fall;
  logic               hard_sync;

  assign presc_m1 = cfg_word[JUMP_LSB-1:0];
  assign jump_m1  = cfg_word[SEG1_LSB-1:JUMP_LSB];
  assign seg1_m1  = cfg_word[SEG2_LSB-1:SEG1_LSB];
  assign seg2_m1  = cfg_word[USED_W-1:SEG2_LSB];

  generate
    if (CFG_W > USED_W) begin : g_spare
      logic [CFG_W-USED_W-1:0] unused_cfg_bits;
      assign unused_cfg_bits = cfg_word[CFG_W-1:USED_W];
    end
  endgenerate

  can_bt_prescaler #(.DIV_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .div_m1  (presc_m1),
    .restart (hard_sync),
    .tq_tick (tq_tick)
  );

  can_bt_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .rx_in   (rx_in),
    .rx_fall (rx_fall)
  );

  can_bt_seq #(
    .JUMP_W (JUMP_W),
    .SEG1_W (SEG1_W),
    .SEG2_W (SEG2_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .jump_m1       (jump_m1),
    .seg1_m1       (seg1_m1),
    .seg2_m1       (seg2_m1),
    .tq_tick       (tq_tick),
    .rx_in         (rx_in),
    .rx_fall       (rx_fall),
    .hsync_en      (hsync_en),
    .tx_bit_in     (tx_bit_in),
    .hard_sync     (hard_sync),
    .tx_out        (tx_out),
    .sample_stb    (sample_stb),
    .rx_bit        (rx_bit),
    .bit_start_stb (bit_start_stb)
  );

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // configuration word, start-to-sample cycles, sample-to-sample cycles
  localparam logic [15:0] CFG_TAB [NVEC] = '{16'h2503, 16'h1240, 16'h7FC7, 16'hA503, 16'h00BF};
  localparam int EXP_B2S [NVEC] = '{28, 4, 136, 28, 128};
  localparam int EXP_S2S [NVEC] = '{40, 6, 200, 40, 192};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_word = 16'h2503;
  logic        rx_in = 1'b1;
  logic        hsync_en = 1'b0;
  logic        tx_bit_in = 1'b1;
  logic        tx_out, sample_stb, rx_bit, bit_start_stb;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  can_bit_timer u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .rx_in(rx_in),
    .hsync_en(hsync_en), .tx_bit_in(tx_bit_in), .tx_out(tx_out),
    .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start_stb(bit_start_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit want_start, output int at);
    int n;
    bit seen;
    n = 0;
    seen = 1'b0;
    while (!seen && n < 4000) begin
      @(negedge clk);
      n++;
      if (want_start ? bit_start_stb : sample_stb) seen = 1'b1;
    end
    at = cyc;
    if (!seen) begin
      checks++;
      errors++;
      $display("FAIL timeout waiting strobe actual 0 expected 1");
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic lengthen(input logic [15:0] cw, input int k, input int exp);
    int c0, c1, s;
    cfg_word = cw; rx_in = 1'b1; hsync_en = 1'b0;
    do_reset();
    wait_pulse(1'b0, s);
    wait_pulse(1'b1, c0);
    repeat (4 * (1 + k) + 1) @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, c1);
    chk("R7 stretched sample", c1 - c0, exp);
    rx_in = 1'b1;
  endtask

  task automatic shorten(input logic [15:0] cw, input int exp);
    int s, c;
    cfg_word = cw; rx_in = 1'b1; hsync_en = 1'b0;
    do_reset();
    wait_pulse(1'b0, s);
    wait_pulse(1'b0, s);
    @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b1, c);
    chk("R8 trimmed phase 2", c - s, exp);
    rx_in = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1, c2, c3, s;
    // R5 reset values
    repeat (2) @(negedge clk);
    chk("R5 tx_out", tx_out, 1);
    chk("R5 rx_bit", rx_bit, 1);
    chk("R5 sample_stb", sample_stb, 0);
    chk("R5 bit_start_stb", bit_start_stb, 0);

    // R1 R2 R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      cfg_word = CFG_TAB[i];
      do_reset();
      wait_pulse(1'b1, c0);
      wait_pulse(1'b0, c1);
      chk("R1 R3 start to sample", c1 - c0, EXP_B2S[i]);
      chk("R3 rx_bit recessive", rx_bit, 1);
      wait_pulse(1'b1, c2);
      chk("R2 sample to start", c2 - c1, EXP_S2S[i] - EXP_B2S[i]);
      wait_pulse(1'b0, c3);
      chk("R2 bit period", c3 - c1, EXP_S2S[i]);
    end

    // R4 transmit update only at bit start
    cfg_word = 16'h2503;
    do_reset();
    tx_bit_in = 1'b0;
    wait_pulse(1'b1, c0);
    chk("R4 tx at start", tx_out, 0);
    tx_bit_in = 1'b1;
    wait_pulse(1'b0, c1);
    chk("R4 tx held mid-bit", tx_out, 0);
    wait_pulse(1'b1, c2);
    chk("R4 tx next start", tx_out, 1);

    // R6 hard sync
    do_reset();
    hsync_en = 1'b1;
    wait_pulse(1'b0, s);
    rx_in = 1'b0;
    wait_pulse(1'b1, c0);
    chk("R6 hard sync start", c0, s + 1);
    wait_pulse(1'b0, c1);
    chk("R6 hard sync sample", c1 - c0, 28);
    hsync_en = 1'b0;
    rx_in = 1'b1;

    // R7 stretch cases
    lengthen(16'h2503, 1, 32);
    lengthen(16'h25C3, 1, 36);
    lengthen(16'h25C3, 0, 32);

    // R8 trim cases
    shorten(16'h2503, 8);
    shorten(16'h25C3, 4);

    // R9 second edge in the same window ignored
    cfg_word = 16'h25C3; rx_in = 1'b1;
    do_reset();
    wait_pulse(1'b0, s);
    wait_pulse(1'b1, c0);
    repeat (9) @(negedge clk);
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    repeat (6) @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, c1);
    chk("R9 single resync", c1 - c0, 36);
    chk("R3 rx_bit dominant", rx_bit, 0);
    rx_in = 1'b1;

    // R10 no resync after dominant sample
    do_reset();
    rx_in = 1'b0;
    wait_pulse(1'b0, s);
    chk("R3 rx_bit dominant sample", rx_bit, 0);
    rx_in = 1'b1;
    wait_pulse(1'b1, c0);
    repeat (9) @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, c1);
    chk("R10 no resync after dominant", c1 - c0, 28);
    rx_in = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule